// File: doc/BRIEF.md
# Memory Test Address Sequencing Engine

This block walks a memory test across a programmed address window. The window is a box in three dimensions: row (X), column (Y) and bank (Z). Each dimension has an inclusive start and end value. Once started, the engine issues one access per cycle to a command back end. It first makes a write pass that covers every address in the window, then a read pass over the same addresses in the same order. Every access carries a fixed data pattern: the nibble 0xA repeated across the data bus. The back end returns a pass/fail flag in the same cycle as each read it is given.

The user programs a small control word. It holds the address order (fast X, fast Y, fast XY or XZY), the rank under test, and the error policy: stop on the first failing read, or carry on to the end of the window. The engine owns the remaining fields of the word. These are a busy indication and the pattern nibble. User writes to those fields never take effect. While a run is in progress, the whole control word is locked. The first failing address and its rank are held until the next run starts. A sticky done flag marks the end of a run.

Top module: `mtest_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `cmd_valid` are 0, and the user fields of `ctl_rdata` (bits 4:0) are 0.
- R2: A `start` pulse seen while idle begins a run on the next clock edge. The run is a write pass of one command per cycle over the whole window, followed at once by a read pass in the same order. In the cycle after the last read, `cmd_valid` and `busy` are 0 and `done` is 1. `done` stays 1 until the next accepted start clears it.
- R3: Order 0 (fast X) steps the row first, then the column, then the bank.
- R4: Order 1 (fast Y) steps the column first, then the row, then the bank.
- R5: Order 2 (fast XY) advances row and column together, each wrapping from its end value back to its start value. A bank is finished when row and column both sit at their end values; the bank then advances and row and column return to their starts.
- R6: Order 3 (XZY) steps the row first, then the bank, then the column.
- R7: Each of row, column and bank spans its start value to its end value inclusive, with start ≤ end. A window of a single point produces exactly one write and one read.
- R8: `cmd_data` is always 0xA repeated in every nibble, and `cmd_rank` equals the rank field of the control word.
- R9: `rsp_err` counts only on read commands. The first failing read sets `fail` and captures its row, column, bank and rank. The capture holds until the next accepted start, which clears `fail`.
- R10: With the halt bit set, no command is issued in the cycle after a failing read, and `done` is 1 from that cycle on.
- R11: With the halt bit clear, a failing read does not stop the run. The run ends as in R2, and the captured address stays that of the first failure.
- R12: A `start` pulse while `busy` is 1 is ignored, and the command sequence goes on unchanged.
- R13: The control word is laid out as follows: bits 1:0 hold the order, bits 3:2 the rank, bit 4 halt, bit 5 busy (read-only), and bits 9:6 the pattern nibble (read-only, always 0xA). Writes are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run request pulse |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 10 | Control word write data |
| ctl_rdata | output | 10 | Control word readback |
| win_start_row | input | 3 | Window first row |
| win_start_col | input | 2 | Window first column |
| win_start_bank | input | 1 | Window first bank |
| win_end_row | input | 3 | Window last row |
| win_end_col | input | 2 | Window last column |
| win_end_bank | input | 1 | Window last bank |
| cmd_valid | output | 1 | Access issued this cycle |
| cmd_write | output | 1 | 1 = write, 0 = read-and-compare |
| cmd_rank | output | 2 | Rank of the access |
| cmd_row | output | 3 | Row of the access |
| cmd_col | output | 2 | Column of the access |
| cmd_bank | output | 1 | Bank of the access |
| cmd_data | output | 16 | Data pattern of the access |
| rsp_err | input | 1 | Compare failure for the current read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (sticky) |
| fail | output | 1 | A read has failed (sticky) |
| fail_rank | output | 2 | Rank of first failure |
| fail_row | output | 3 | Row of first failure |
| fail_col | output | 2 | Column of first failure |
| fail_bank | output | 1 | Bank of first failure |

## Verification
Two things can land in the same cycle: an error capture and run completion. This happens when the failing read is also the last address of the read pass. The bench forces this case by placing the injected error on the end corner of a one-bank window. It does so in both halt and continue modes. It then checks in the following cycle that `done` and `fail` are both set, that the captured address is the end corner, and that no extra command was issued. A second overlap is a start pulse that arrives while the write pass is running. The bench judges it by an unchanged command sequence and an unchanged control word.

// File: rtl/mtest_pkg.sv
// Package: shared encodings for the memory test sequencer.
// Assumes: the control word layout described in mtest_ctl_reg.
package mtest_pkg;

    typedef enum logic [1:0] {
        ORD_FAST_X  = 2'd0,
        ORD_FAST_Y  = 2'd1,
        ORD_FAST_XY = 2'd2,
        ORD_XZY     = 2'd3
    } order_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_e;

    localparam logic [3:0] FILL_NIBBLE = 4'hA;

endpackage

// File: rtl/mtest_ctl_reg.sv
// Module: control word holding the user's order, rank and halt choice.
// The busy bit and the pattern nibble are driven by the engine, so writes
// to them never take effect. The whole word is frozen while a run is active.
// Assumes: busy comes from the sequencer phase register.
module mtest_ctl_reg
    import mtest_pkg::*;
#(
    parameter int RANK_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                busy,
    input  logic                wr_en,
    input  logic [RANK_W+7:0]   wr_data,
    output logic [RANK_W+7:0]   rd_data,
    output order_e              order,
    output logic [RANK_W-1:0]   rank,
    output logic                halt
);
    localparam int RANK_LSB = 2;
    localparam int HALT_BIT = RANK_LSB + RANK_W;

    order_e             order_q;
    logic [RANK_W-1:0]  rank_q;
    logic               halt_q;

    // Load the user fields when idle; ignore every write while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= ORD_FAST_X;
            rank_q  <= '0;
            halt_q  <= 1'b0;
        end else if (wr_en && !busy) begin
            order_q <= order_e'(wr_data[1:0]);
            rank_q  <= wr_data[RANK_LSB +: RANK_W];
            halt_q  <= wr_data[HALT_BIT];
        end
    end

    // Readback combines the user fields with the engine-owned fields.
    always_comb begin
        rd_data = {FILL_NIBBLE, busy, halt_q, rank_q, order_q};
    end

    assign order = order_q;
    assign rank  = rank_q;
    assign halt  = halt_q;

    AST_CTL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(order_q) && $stable(rank_q) && $stable(halt_q)));  // R13

endmodule

// File: rtl/mtest_addr_gen.sv
// Module: three-dimensional address walker over an inclusive window.
// On load it captures the window and sits at the start corner. On rewind
// it returns to the start corner of the captured window. On step it moves
// to the next address in the selected order. last marks the final address.
// Assumes: start <= end in every dimension.
module mtest_addr_gen
    import mtest_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 2,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rewind,
    input  logic              step,
    input  order_e            order,
    input  logic [ROW_W-1:0]  in_start_row,
    input  logic [COL_W-1:0]  in_start_col,
    input  logic [BANK_W-1:0] in_start_bank,
    input  logic [ROW_W-1:0]  in_end_row,
    input  logic [COL_W-1:0]  in_end_col,
    input  logic [BANK_W-1:0] in_end_bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank,
    output logic              last
);
    logic [ROW_W-1:0]  s_row, e_row, row_q, row_n, row_inc;
    logic [COL_W-1:0]  s_col, e_col, col_q, col_n, col_inc;
    logic [BANK_W-1:0] s_bank, e_bank, bank_q, bank_n, bank_inc;
    logic              row_top, col_top, bank_top;

    // Capture the window bounds when a run is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_row  <= '0;
            e_row  <= '0;
            s_col  <= '0;
            e_col  <= '0;
            s_bank <= '0;
            e_bank <= '0;
        end else if (load) begin
            s_row  <= in_start_row;
            e_row  <= in_end_row;
            s_col  <= in_start_col;
            e_col  <= in_end_col;
            s_bank <= in_start_bank;
            e_bank <= in_end_bank;
        end
    end

    // Per-dimension wrap detection and wrapped increment.
    always_comb begin
        row_top  = (row_q == e_row);
        col_top  = (col_q == e_col);
        bank_top = (bank_q == e_bank);
        row_inc  = row_top  ? s_row  : ROW_W'(row_q + 1'b1);
        col_inc  = col_top  ? s_col  : COL_W'(col_q + 1'b1);
        bank_inc = bank_top ? s_bank : BANK_W'(bank_q + 1'b1);
    end

    // Next address for the selected ordering.
    always_comb begin
        row_n  = row_q;
        col_n  = col_q;
        bank_n = bank_q;
        unique case (order)
            ORD_FAST_X: begin
                row_n = row_inc;
                if (row_top) col_n = col_inc;
                if (row_top && col_top) bank_n = bank_inc;
            end
            ORD_FAST_Y: begin
                col_n = col_inc;
                if (col_top) row_n = row_inc;
                if (col_top && row_top) bank_n = bank_inc;
            end
            ORD_FAST_XY: begin
                if (row_top && col_top) begin
                    row_n  = s_row;
                    col_n  = s_col;
                    bank_n = bank_inc;
                end else begin
                    row_n = row_inc;
                    col_n = col_inc;
                end
            end
            ORD_XZY: begin
                row_n = row_inc;
                if (row_top) bank_n = bank_inc;
                if (row_top && bank_top) col_n = col_inc;
            end
            default: ;
        endcase
    end

    // Position register: load or rewind to the start corner, else step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            bank_q <= '0;
        end else if (load) begin
            row_q  <= in_start_row;
            col_q  <= in_start_col;
            bank_q <= in_start_bank;
        end else if (rewind) begin
            row_q  <= s_row;
            col_q  <= s_col;
            bank_q <= s_bank;
        end else if (step) begin
            row_q  <= row_n;
            col_q  <= col_n;
            bank_q <= bank_n;
        end
    end

    assign row  = row_q;
    assign col  = col_q;
    assign bank = bank_q;
    assign last = row_top && col_top && bank_top;

    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step && !load) |-> (row_q >= s_row && row_q <= e_row &&
                                  col_q >= s_col && col_q <= e_col &&
                                  bank_q >= s_bank && bank_q <= e_bank));  // R7

endmodule

// File: rtl/mtest_err_log.sv
// Module: first-failure capture. It records the address and rank of the
// first failing read and holds them until clr.
// Assumes: chk is high only on read commands.
module mtest_err_log #(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 2,
    parameter int BANK_W = 1,
    parameter int RANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              chk,
    input  logic              err,
    input  logic [RANK_W-1:0] rank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [BANK_W-1:0] bank,
    output logic              fail,
    output logic [RANK_W-1:0] fail_rank,
    output logic [ROW_W-1:0]  fail_row,
    output logic [COL_W-1:0]  fail_col,
    output logic [BANK_W-1:0] fail_bank
);
    logic fail_q;

    // Capture the first failing read; clear at the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q    <= 1'b0;
            fail_rank <= '0;
            fail_row  <= '0;
            fail_col  <= '0;
            fail_bank <= '0;
        end else if (clr) begin
            fail_q <= 1'b0;
        end else if (chk && err && !fail_q) begin
            fail_q    <= 1'b1;
            fail_rank <= rank;
            fail_row  <= row;
            fail_col  <= col;
            fail_bank <= bank;
        end
    end

    assign fail = fail_q;

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !clr) |=> (fail_q && $stable(fail_row) && $stable(fail_col) &&
                              $stable(fail_bank) && $stable(fail_rank)));  // R9

endmodule

// File: rtl/mtest_seq.sv
// Module: top of the memory test sequencer. A phase machine runs a write
// pass and then a read pass over the window, one command per cycle. It
// stops early in halt mode on a failing read.
// Assumes: the back end accepts one command every cycle and reports the
// compare result of a read in the same cycle.
module mtest_seq
    import mtest_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 2,
    parameter int BANK_W = 1,
    parameter int RANK_W = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ctl_we,
    input  logic [RANK_W+7:0] ctl_wdata,
    output logic [RANK_W+7:0] ctl_rdata,
    input  logic [ROW_W-1:0]  win_start_row,
    input  logic [COL_W-1:0]  win_start_col,
    input  logic [BANK_W-1:0] win_start_bank,
    input  logic [ROW_W-1:0]  win_end_row,
    input  logic [COL_W-1:0]  win_end_col,
    input  logic [BANK_W-1:0] win_end_bank,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [RANK_W-1:0] cmd_rank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [DATA_W-1:0] cmd_data,
    input  logic              rsp_err,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [RANK_W-1:0] fail_rank,
    output logic [ROW_W-1:0]  fail_row,
    output logic [COL_W-1:0]  fail_col,
    output logic [BANK_W-1:0] fail_bank
);
    localparam int NIBBLES = DATA_W / 4;

    phase_e             phase_q;
    logic               done_q;
    logic               accept, rewind, step, at_last, stop_now;
    order_e             cfg_order;
    logic [RANK_W-1:0]  cfg_rank;
    logic               cfg_halt;

    mtest_ctl_reg #(.RANK_W(RANK_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_en   (ctl_we),
        .wr_data (ctl_wdata),
        .rd_data (ctl_rdata),
        .order   (cfg_order),
        .rank    (cfg_rank),
        .halt    (cfg_halt)
    );

    mtest_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (accept),
        .rewind        (rewind),
        .step          (step),
        .order         (cfg_order),
        .in_start_row  (win_start_row),
        .in_start_col  (win_start_col),
        .in_start_bank (win_start_bank),
        .in_end_row    (win_end_row),
        .in_end_col    (win_end_col),
        .in_end_bank   (win_end_bank),
        .row           (cmd_row),
        .col           (cmd_col),
        .bank          (cmd_bank),
        .last          (at_last)
    );

    mtest_err_log #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .RANK_W(RANK_W)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .chk       (phase_q == PH_READ),
        .err       (rsp_err),
        .rank      (cfg_rank),
        .row       (cmd_row),
        .col       (cmd_col),
        .bank      (cmd_bank),
        .fail      (fail),
        .fail_rank (fail_rank),
        .fail_row  (fail_row),
        .fail_col  (fail_col),
        .fail_bank (fail_bank)
    );

    // Control strobes derived from the phase and the walker position.
    always_comb begin
        accept   = start && (phase_q == PH_IDLE);
        rewind   = (phase_q == PH_WRITE) && at_last;
        step     = (phase_q != PH_IDLE) && !rewind;
        stop_now = (phase_q == PH_READ) && (at_last || (rsp_err && cfg_halt));
    end

    // Phase machine: idle, write pass, read pass; done is sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q <= PH_WRITE;
                        done_q  <= 1'b0;
                    end
                end
                PH_WRITE: begin
                    if (at_last) phase_q <= PH_READ;
                end
                PH_READ: begin
                    if (stop_now) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Command outputs follow the phase; data is the fixed fill pattern.
    always_comb begin
        busy      = (phase_q != PH_IDLE);
        cmd_valid = busy;
        cmd_write = (phase_q == PH_WRITE);
        cmd_rank  = cfg_rank;
        cmd_data  = {NIBBLES{FILL_NIBBLE}};
        done      = done_q;
    end

    AST_HALT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write && rsp_err && cfg_halt) |=> (!cmd_valid && done));  // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(phase_q == PH_READ && at_last) && !(rsp_err && cfg_halt && !cmd_write))
            |=> busy);  // R12

    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cmd_valid && !cmd_write));  // R2

    AST_WRITE_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |=> (!busy || cmd_write));  // R2

endmodule

// File: tb/mtest_seq_test.sv
// Bench: sweeps every order over several windows, injects read errors in
// halt and continue modes, and checks each command against a sequence
// built from nested loops.
module mtest_seq_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ctl_we = 1'b0;
    logic [9:0] ctl_wdata = '0;
    logic [9:0] ctl_rdata;
    logic [2:0] ws_row = '0, we_row = '0;
    logic [1:0] ws_col = '0, we_col = '0;
    logic [0:0] ws_bank = '0, we_bank = '0;
    logic       cmd_valid, cmd_write;
    logic [1:0] cmd_rank;
    logic [2:0] cmd_row;
    logic [1:0] cmd_col;
    logic [0:0] cmd_bank;
    logic [15:0] cmd_data;
    logic       rsp_err;
    logic       busy, done, fail;
    logic [1:0] fail_rank;
    logic [2:0] fail_row;
    logic [1:0] fail_col;
    logic [0:0] fail_bank;

    logic       inj_en = 1'b0;
    logic [2:0] inj_row = '0;
    logic [1:0] inj_col = '0;

    int n_chk = 0;
    int n_bad = 0;

    int exp_r [0:63];
    int exp_c [0:63];
    int exp_b [0:63];
    int exp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Error model: every access at the chosen row/column reports a miscompare.
    assign rsp_err = inj_en && cmd_valid && cmd_row == inj_row && cmd_col == inj_col;

    mtest_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .win_start_row(ws_row), .win_start_col(ws_col), .win_start_bank(ws_bank),
        .win_end_row(we_row), .win_end_col(we_col), .win_end_bank(we_bank),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_rank(cmd_rank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_bank(cmd_bank),
        .cmd_data(cmd_data), .rsp_err(rsp_err), .busy(busy), .done(done),
        .fail(fail), .fail_rank(fail_rank), .fail_row(fail_row),
        .fail_col(fail_col), .fail_bank(fail_bank)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected order built directly from R3..R6 nesting rules.
    task automatic build(input int ord, input int sr, input int er, input int sc,
                         input int ec, input int sb, input int eb);
        exp_n = 0;
        case (ord)
            0: for (int b = sb; b <= eb; b++) for (int c = sc; c <= ec; c++)
                   for (int r = sr; r <= er; r++) begin
                       exp_r[exp_n] = r; exp_c[exp_n] = c; exp_b[exp_n] = b; exp_n++;
                   end
            1: for (int b = sb; b <= eb; b++) for (int r = sr; r <= er; r++)
                   for (int c = sc; c <= ec; c++) begin
                       exp_r[exp_n] = r; exp_c[exp_n] = c; exp_b[exp_n] = b; exp_n++;
                   end
            3: for (int c = sc; c <= ec; c++) for (int b = sb; b <= eb; b++)
                   for (int r = sr; r <= er; r++) begin
                       exp_r[exp_n] = r; exp_c[exp_n] = c; exp_b[exp_n] = b; exp_n++;
                   end
            default: for (int b = sb; b <= eb; b++) begin
                int r = sr;
                int c = sc;
                for (int k = 0; k < 32; k++) begin
                    exp_r[exp_n] = r; exp_c[exp_n] = c; exp_b[exp_n] = b; exp_n++;
                    if (r == er && c == ec) break;
                    r = (r == er) ? sr : r + 1;
                    c = (c == ec) ? sc : c + 1;
                end
            end
        endcase
    endtask

    task automatic run_case(input int ord, input int sr, input int er, input int sc,
                            input int ec, input int sb, input int eb, input bit halt,
                            input int rank, input bit inj, input int ir, input int ic,
                            input bit poke);
        string oreq;
        int first_bad;
        int n_reads;
        int total;
        logic [9:0] rd_before;
        oreq = (ord == 0) ? "R3" : (ord == 1) ? "R4" : (ord == 2) ? "R5" : "R6";
        build(ord, sr, er, sc, ec, sb, eb);
        first_bad = -1;
        if (inj)
            for (int i = 0; i < exp_n; i++)
                if (first_bad < 0 && exp_r[i] == ir && exp_c[i] == ic) first_bad = i;
        n_reads = (halt && first_bad >= 0) ? first_bad + 1 : exp_n;
        total = exp_n + n_reads;

        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = {4'h0, 1'b0, halt, 2'(rank), 2'(ord)};
        ws_row = 3'(sr); we_row = 3'(er);
        ws_col = 2'(sc); we_col = 2'(ec);
        ws_bank = 1'(sb); we_bank = 1'(eb);
        inj_en = inj; inj_row = 3'(ir); inj_col = 2'(ic);
        @(negedge clk);
        ctl_we = 1'b0;
        rd_before = ctl_rdata;
        start = 1'b1;
        for (int i = 0; i < total; i++) begin
            int k;
            @(negedge clk);
            start = 1'b0;
            ctl_we = 1'b0;
            k = (i < exp_n) ? i : i - exp_n;
            chk(cmd_valid && busy, "R2", "command issued", int'(cmd_valid), 1);
            chk(cmd_write == (i < exp_n), "R2", "pass direction", int'(cmd_write), int'(i < exp_n));
            chk(int'(cmd_row) == exp_r[k], oreq, "row", int'(cmd_row), exp_r[k]);
            chk(int'(cmd_col) == exp_c[k], oreq, "column", int'(cmd_col), exp_c[k]);
            chk(int'(cmd_bank) == exp_b[k], "R7", "bank", int'(cmd_bank), exp_b[k]);
            chk(cmd_data == 16'hAAAA && int'(cmd_rank) == rank, "R8", "data/rank",
                int'(cmd_data), 16'hAAAA);
            if (i == 0) chk(!done && !fail, "R2", "start clears done/fail", int'(done), 0);
            if (poke && i == 1) begin
                start = 1'b1;
                ctl_we = 1'b1;
                ctl_wdata = ~ctl_wdata;
            end
        end
        @(negedge clk);
        chk(!cmd_valid && !busy, halt && inj ? "R10" : "R2", "stopped", int'(cmd_valid), 0);
        chk(done, halt && inj ? "R10" : "R2", "done", int'(done), 1);
        chk(fail == (first_bad >= 0), inj ? (halt ? "R10" : "R11") : "R9", "fail flag",
            int'(fail), int'(first_bad >= 0));
        if (first_bad >= 0) begin
            chk(int'(fail_row) == exp_r[first_bad] && int'(fail_col) == exp_c[first_bad],
                "R9", "captured row/col", int'(fail_row), exp_r[first_bad]);
            chk(int'(fail_bank) == exp_b[first_bad] && int'(fail_rank) == rank,
                "R9", "captured bank/rank", int'(fail_bank), exp_b[first_bad]);
        end
        if (poke) begin
            chk(ctl_rdata == rd_before, "R13", "word locked while busy",
                int'(ctl_rdata), int'(rd_before));
            chk(total == 2 * exp_n, "R12", "sequence length", total, 2 * exp_n);
        end
        repeat (3) @(negedge clk);
        chk(!cmd_valid && done, "R12", "stays idle", int'(cmd_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !fail && !cmd_valid, "R1", "idle flags", int'(busy), 0);
        chk(ctl_rdata[4:0] == 5'd0, "R1", "user fields", int'(ctl_rdata[4:0]), 0);
        // R13: owned fields ignore writes
        ctl_we = 1'b1;
        ctl_wdata = 10'h3FF;
        @(negedge clk);
        ctl_we = 1'b0;
        chk(ctl_rdata[9:5] == 5'b10100, "R13", "owned fields", int'(ctl_rdata[9:5]), 5'b10100);
        chk(ctl_rdata[4:0] == 5'h1F, "R13", "user fields written", int'(ctl_rdata[4:0]), 5'h1F);

        for (int ord = 0; ord < 4; ord++) begin
            run_case(ord, 0, 7, 0, 3, 0, 1, 1'b0, ord, 1'b0, 0, 0, 1'b0);
            run_case(ord, 2, 5, 1, 3, 1, 1, 1'b0, 3 - ord, 1'b0, 0, 0, 1'b0);
            run_case(ord, 1, 3, 2, 3, 0, 1, 1'b0, 1, 1'b0, 0, 0, 1'b0);
            run_case(ord, 3, 3, 2, 2, 0, 0, 1'b0, 2, 1'b0, 0, 0, 1'b0);  // R7 single point
        end
        // R12, R13: start and write while busy
        run_case(0, 0, 3, 0, 1, 0, 1, 1'b0, 1, 1'b0, 0, 0, 1'b1);
        run_case(2, 0, 2, 0, 1, 0, 1, 1'b0, 2, 1'b0, 0, 0, 1'b1);
        // R10: halt on the first failing read
        run_case(0, 0, 7, 0, 3, 0, 1, 1'b1, 2, 1'b1, 5, 2, 1'b0);
        run_case(3, 0, 7, 0, 3, 0, 1, 1'b1, 1, 1'b1, 0, 0, 1'b0);
        // R11: continue; two failing addresses, first one captured
        run_case(1, 0, 7, 0, 3, 0, 1, 1'b0, 3, 1'b1, 6, 1, 1'b0);
        run_case(2, 0, 7, 0, 3, 0, 1, 1'b0, 0, 1'b1, 4, 0, 1'b0);
        // Failure on the very last read: capture and completion coincide
        run_case(0, 1, 4, 0, 2, 1, 1, 1'b1, 1, 1'b1, 4, 2, 1'b0);
        run_case(0, 1, 4, 0, 2, 1, 1, 1'b0, 2, 1'b1, 4, 2, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule